// File: doc/BRIEF.md
# Flash Controller Interrupt Status Unit

This unit collects the completion and fault events of a flash memory controller into a latched status register and drives one active-high level interrupt request. Each event reaches the unit as a one-cycle pulse: flash device ready, controller ready, decode failure, decode error, ECC ready and write-protect fault. Each pulse sets its own sticky bit. Reading the latched status register returns the bits and clears them all in the same access. A mask register selects which latched bits raise the interrupt. After reset the mask is all zero, so every source is disabled.

A third register reports live state and has no side effects. It shows the two ready levels, the ECC ready level, a decoder-failure flag and an errors-detected flag. It also carries a two-bit field that gives the corrected-symbol count minus one. The errors-detected flag and the count field are suppressed while the decoder-failure flag is set. Software reads this register after a decode to judge the result.

Top module: `fevt_irq_top`

## Requirements
- R1: After reset the latched status and the mask are all zero, irq_o is low and rd_data_o is zero.
- R2: A pulse on evt_i sets the matching latched bit one cycle later, and the bit stays set until the status is read. The bit positions are 5 flash ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready and 0 write-protect fault.
- R3: A read at address 0 puts the latched status on rd_data_o[5:0] on the cycle after rd_en_i, with bits [7:6] zero. The same read clears every latched bit.
- R4: An event pulse that arrives in the same cycle as a status read is not returned by that read. It stays latched and is returned by the next status read.
- R5: irq_o is high exactly while some latched bit is set whose mask bit is also set. A masked-off bit still latches but does not raise irq_o.
- R6: A write at address 1 loads wr_data_i[5:0] into the mask, using the same bit positions as the status. A read at address 1 returns the mask, with bits [7:6] zero.
- R7: A read at address 2 returns the live raw status. Bit 0 is flash ready, bit 1 is controller ready, bit 2 is ECC ready, bit 3 is errors detected, bit 6 is decoder failure and bit 7 is zero. The read leaves the latched status unchanged.
- R8: Raw bits [5:4] hold (corr_cnt_i - 1) mod 4 while bit 3 is shown, and zero otherwise. While decoder failure is set, bit 3 and bits [5:4] read zero.
- R9: Writes to address 0 or address 2 change neither the latched status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | One-cycle event pulses, in status bit order |
| dev_rdy_i | input | 1 | Live flash device ready level |
| ctl_rdy_i | input | 1 | Live controller ready level |
| ecc_rdy_i | input | 1 | Live ECC ready level |
| dec_fail_i | input | 1 | Live decoder failure flag |
| err_det_i | input | 1 | Live errors-detected flag |
| corr_cnt_i | input | 3 | Number of corrected symbols (1 to 4) |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 mask, 2 raw |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Level interrupt request |

## Verification
A latched bit appears one clock edge after its pulse, and irq_o follows it with no further register stage. The bench therefore checks irq_o at the falling edge that follows the pulse's capture edge. Read data is registered once. The driver pushes the expected word into the queue at the request, and the monitor compares it at the falling edge one cycle after the strobe. Raw status is sampled at the read's capture edge, so the live inputs are held steady across that edge.

// File: rtl/fevt_pkg.sv
package fevt_pkg;
    localparam int EVT_N  = 6;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int CNT_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STAT = 2'd0,
        SEL_MASK = 2'd1,
        SEL_RAW  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [EVT_N-1:0]  mask;
        logic [DATA_W-1:0] rdata;
    } top_regs_t;
endpackage

// File: rtl/fevt_latch.sv
module fevt_latch #(
    parameter int EVT_N = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             clr_i,
    output logic [EVT_N-1:0] stat_o
);
    typedef struct packed {
        logic [EVT_N-1:0] stat;
    } latch_regs_t;

    latch_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // A clear wipes old bits only; a coincident event survives
        r_d.stat = (clr_i ? '0 : r_q.stat) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat_o = r_q.stat;

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i))); // R2
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i == '0) |=> (stat_o == '0)); // R3
    AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> ((stat_o & $past(stat_o)) == $past(stat_o))); // R4
endmodule

// File: rtl/fevt_raw_enc.sv
module fevt_raw_enc #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              dev_rdy_i,
    input  logic              ctl_rdy_i,
    input  logic              ecc_rdy_i,
    input  logic              dec_fail_i,
    input  logic              err_det_i,
    input  logic [CNT_W-1:0]  corr_cnt_i,
    output logic [DATA_W-1:0] raw_o
);
    localparam int FLD_W = 2;

    logic             shown_err;
    logic [CNT_W-1:0] cnt_m1;
    logic [FLD_W-1:0] cnt_fld;

    always_comb begin
        shown_err = err_det_i && !dec_fail_i;
        cnt_m1    = corr_cnt_i - CNT_W'(1);
        cnt_fld   = shown_err ? cnt_m1[FLD_W-1:0] : '0;
        raw_o     = '0;
        raw_o[0]  = dev_rdy_i;
        raw_o[1]  = ctl_rdy_i;
        raw_o[2]  = ecc_rdy_i;
        raw_o[3]  = shown_err;
        raw_o[5:4] = cnt_fld;
        raw_o[6]  = dec_fail_i;
    end

    always_comb begin
        AST_FAIL_EXCLUDES_ERR: assert (!(raw_o[6] && raw_o[3])); // R8
    end
endmodule

// File: rtl/fevt_irq_top.sv
module fevt_irq_top
    import fevt_pkg::*;
#(
    parameter int NEVT = EVT_N,
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int CW   = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NEVT-1:0] evt_i,
    input  logic          dev_rdy_i,
    input  logic          ctl_rdy_i,
    input  logic          ecc_rdy_i,
    input  logic          dec_fail_i,
    input  logic          err_det_i,
    input  logic [CW-1:0] corr_cnt_i,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_o
);
    localparam int PAD_W = DW - NEVT;

    logic [NEVT-1:0] stat;
    logic [DW-1:0]   raw;
    logic            rd_stat;
    logic [NEVT-1:0] mask_d, mask_q;
    logic [DW-1:0]   rdata_d, rdata_q;

    assign rd_stat = rd_en_i && (addr_i == SEL_STAT);

    fevt_latch #(.EVT_N(NEVT)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (rd_stat),
        .stat_o (stat)
    );

    fevt_raw_enc #(.DATA_W(DW), .CNT_W(CW)) u_raw (
        .dev_rdy_i  (dev_rdy_i),
        .ctl_rdy_i  (ctl_rdy_i),
        .ecc_rdy_i  (ecc_rdy_i),
        .dec_fail_i (dec_fail_i),
        .err_det_i  (err_det_i),
        .corr_cnt_i (corr_cnt_i),
        .raw_o      (raw)
    );

    always_comb begin
        mask_d  = mask_q;
        rdata_d = rdata_q;
        if (wr_en_i && addr_i == SEL_MASK)
            mask_d = wr_data_i[NEVT-1:0];
        if (rd_en_i) begin
            case (addr_i)
                SEL_STAT: rdata_d = {{PAD_W{1'b0}}, stat};
                SEL_MASK: rdata_d = {{PAD_W{1'b0}}, mask_q};
                SEL_RAW:  rdata_d = raw;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rdata_q <= '0;
        end else begin
            mask_q  <= mask_d;
            rdata_q <= rdata_d;
        end
    end

    assign rd_data_o = rdata_q;
    assign irq_o     = |(stat & mask_q);

    AST_IRQ_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rd_stat && !(wr_en_i && addr_i == SEL_MASK)) |=> irq_o); // R5
    AST_RAW_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == SEL_RAW && evt_i == '0) |=> $stable(stat)); // R7
    AST_MASK_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == SEL_MASK) |=> $stable(mask_q)); // R9
endmodule

// File: tb/fevt_irq_top_tb_top.sv
module fevt_irq_top_tb_top;
    logic clk = 0;
    logic rst_n = 0;
    logic [5:0] evt_i = '0;
    logic dev_rdy_i = 0, ctl_rdy_i = 0, ecc_rdy_i = 0, dec_fail_i = 0, err_det_i = 0;
    logic [2:0] corr_cnt_i = 3'd1;
    logic rd_en_i = 0, wr_en_i = 0;
    logic [1:0] addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic irq_o;

    int n_run = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 0;
    logic [5:0] m_stat = '0, m_mask = '0;

    always #2 clk = ~clk;

    fevt_irq_top dut_i (.*);

    always @(posedge clk) rd_seen <= rd_en_i;

    // monitor: read data is due one cycle after the strobe
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (rd_data_o !== e) begin
                n_fail++;
                $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data_o, e);
            end
        end
    end

    task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string t, logic [5:0] ev = '0);
        @(negedge clk);
        rd_en_i = 1; addr_i = a; evt_i = ev;
        exp_q.push_back(exp); tag_q.push_back(t);
        if (a == 2'd0) m_stat = ev; else m_stat |= ev;
        @(negedge clk);
        rd_en_i = 0; evt_i = '0;
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1; addr_i = a; wr_data_i = d;
        if (a == 2'd1) m_mask = d[5:0];
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic pulse(logic [5:0] ev);
        @(negedge clk);
        evt_i = ev;
        m_stat |= ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    function automatic logic [7:0] raw_exp(logic nr, logic cr, logic er, logic df, logic ed, logic [2:0] c);
        logic [7:0] v;
        logic [2:0] cm;
        v = '0;
        cm = c - 3'd1;
        v[0] = nr; v[1] = cr; v[2] = er; v[6] = df;
        if (ed && !df) begin v[3] = 1; v[5:4] = cm[1:0]; end
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq after reset", {7'd0, irq_o}, 8'd0);
        chk("R1 rdata after reset", rd_data_o, 8'd0);
        rst_n = 1;
        rd(2'd0, 8'h00, "R1 status zero");
        rd(2'd1, 8'h00, "R1 mask zero");

        // R2: each source latches, no irq while masked
        for (int i = 0; i < 6; i++) begin
            pulse(6'(1) << i);
            chk("R5 masked no irq", {7'd0, irq_o}, 8'd0);
            rd(2'd0, 8'(6'(1) << i), "R2 single bit latch");
        end
        pulse(6'h21); pulse(6'h04);
        rd(2'd0, 8'h25, "R2 accumulate");
        rd(2'd0, 8'h00, "R3 cleared by read");

        // R4 coincident event
        pulse(6'h02);
        rd(2'd0, 8'h02, "R4 read with coincident evt", 6'h10);
        rd(2'd0, 8'h10, "R4 coincident evt kept");

        // R6 mask
        wr(2'd1, 8'hF1);
        rd(2'd1, 8'h31, "R6 mask readback");

        // R5 irq
        pulse(6'h02);
        chk("R5 unmasked bit irq low", {7'd0, irq_o}, 8'd0);
        pulse(6'h10);
        chk("R5 irq high", {7'd0, irq_o}, 8'd1);
        wr(2'd1, 8'h02);
        chk("R5 irq after mask change", {7'd0, irq_o}, 8'd1);
        wr(2'd1, 8'h00);
        chk("R5 irq off when masked", {7'd0, irq_o}, 8'd0);
        wr(2'd1, 8'h10);

        // R9 writes elsewhere ignored
        wr(2'd0, 8'hFF); wr(2'd2, 8'hFF);
        m_mask = 6'h10;
        rd(2'd1, 8'h10, "R9 mask unchanged");
        chk("R9 irq still set", {7'd0, irq_o}, 8'd1);

        // R7 raw read has no side effect
        dev_rdy_i = 1; ctl_rdy_i = 1; ecc_rdy_i = 0;
        rd(2'd2, raw_exp(1,1,0,0,0,3'd1), "R7 raw ready levels");
        chk("R7 irq unaffected", {7'd0, irq_o}, 8'd1);
        rd(2'd0, 8'h12, "R7 status intact after raw read");
        chk("R3 irq drops after read", {7'd0, irq_o}, 8'd0);

        // R8 count encoding and priority
        for (int c = 1; c <= 4; c++) begin
            dev_rdy_i = 0; ctl_rdy_i = 1; ecc_rdy_i = 1; err_det_i = 1; dec_fail_i = 0;
            corr_cnt_i = 3'(c);
            rd(2'd2, raw_exp(0,1,1,0,1,3'(c)), "R8 count field");
        end
        dec_fail_i = 1; corr_cnt_i = 3'd3;
        rd(2'd2, 8'h46, "R8 failure suppresses errors");
        err_det_i = 0; dec_fail_i = 0; corr_cnt_i = 3'd4;
        rd(2'd2, 8'h06, "R8 no errors field zero");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard left %0d items", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule